// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte stream into host memory. It follows a chain of four-word descriptors. Word 0 of each descriptor is a link pointer to the next descriptor. Word 1 is a command/status word. Word 2 is the start address of a buffer. Word 3 is unused. After reset the engine waits for a `kick` pulse. It then takes the first descriptor address from `ring_base` and reads the command/status word at offset 4. Only when the host has handed the descriptor over does it go on to read the link and buffer words and accept a frame.

Frame bytes enter on a valid/ready stream that carries start-of-frame, end-of-frame and a good flag. A byte is transferred on a rising edge where `in_valid` and `in_ready` are both high. The source must hold the byte and its flags steady while `in_valid` is high and `in_ready` is low. The engine packs the bytes little-endian into 32-bit words and writes each word into the buffer.

Memory is reached through one word-wide request port that follows the same valid/ready rule: the engine holds a request steady until `mem_req_ready` is seen. Read data returns on `mem_rsp_valid` on any later cycle, with no back-pressure on the response. Once every data word has been accepted, the engine writes the status word back. That write returns the descriptor to the host. The engine then follows the link pointer, so two descriptors that point at each other form a ring.

Top module: `rxd_ring_engine`

## Requirements
- R1: After reset the engine is idle: `mem_req_valid`, `in_ready`, `stalled` and `frame_done` are all low until `kick` is seen.
- R2: A `kick` while idle loads `ring_base` as the current descriptor address. The engine then issues three reads in this order: the status word (base+4), the link word (base+0) and the buffer word (base+8).
- R3: If bit 31 (ownership) of the fetched status word is 0, the engine stops with `stalled` high and `in_ready` high. Every incoming byte is dropped and no memory write is made. A later `kick` re-reads the same descriptor.
- R4: Stored byte k of a frame is written to address buffer+4*(k/4), in byte lane k%4 (bits 8*(k%4)+7 to 8*(k%4)). Only lanes holding frame bytes have their `mem_req_be` bit set, so a partial last word leaves the other lanes untouched.
- R5: Bytes that arrive outside a frame, before any byte with `in_sof` set, are consumed and discarded.
- R6: The write-back goes to descriptor+4 and is made only after every data word has been accepted. Bit 31 is 0. Bit 27 is `in_good` of the last byte, provided the frame was not truncated. Bits 11:0 hold the number of stored bytes, which includes the 4 trailing check bytes of the stream. All other bits are 0.
- R7: A frame longer than the posted size (bits 11:0 of the fetched status word) has only its first `size` bytes written. The length written back equals `size`, and bit 27 is 0.
- R8: After a write-back the engine fetches the descriptor at that descriptor's link pointer.
- R9: A memory request is held with a stable address, write flag and data while `mem_req_ready` is low. At most one read is outstanding.
- R10: `in_ready` is low while a descriptor read or the status write-back is in progress.
- R11: `frame_done` pulses high for exactly one cycle for each status write-back that memory accepts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | First descriptor address, taken on `kick` from idle |
| kick | input | 1 | Start from idle, or re-read the descriptor when stalled |
| stalled | output | 1 | Current descriptor is not owned by the engine |
| frame_done | output | 1 | One-cycle pulse when a status write-back is accepted |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_good | input | 1 | Frame received without error, sampled with the last byte |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Byte lane enables for writes |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |

## Verification
The bound checker watches several behaviours on every cycle. It checks that requests are held steady under back-pressure and that only one read is outstanding. It checks that the stream is blocked while descriptor traffic is in progress and that a stalled engine drains its input. During the write-back it checks that the ownership bit is clear, that no data word is still pending and that the written length never exceeds the posted size. Two kinds of behaviour only the bench scenarios can show. The first is how bytes land in memory: lane placement, partial last words, truncation and untouched bytes past the end. The second is how the status values come out, including the fetch order, the walk around the ring and recovery from a stall.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int WORD_W  = 32;
  localparam int OWN_BIT = 31;
  localparam int OK_BIT  = 27;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ISSUE,
    ST_RD_WAIT,
    ST_STALL,
    ST_RECV,
    ST_WB
  } rxd_state_e;
endpackage

// File: rtl/rxd_desc_latch.sv
module rxd_desc_latch #(
  parameter int AW    = 32,
  parameter int LEN_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [1:0]                sel,
  input  logic [rxd_pkg::WORD_W-1:0] word,
  output logic                      own,
  output logic [LEN_W-1:0]          size,
  output logic [AW-1:0]             link,
  output logic [AW-1:0]             buf_base
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own      <= 1'b0;
      size     <= '0;
      link     <= '0;
      buf_base <= '0;
    end else if (load) begin
      case (sel)
        2'd0: begin
          own  <= word[rxd_pkg::OWN_BIT];
          size <= word[LEN_W-1:0];
        end
        2'd1:    link     <= word[AW-1:0];
        default: buf_base <= word[AW-1:0];
      endcase
    end
  end
endmodule

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int LEN_W = 12,
  localparam int WIDX_W = LEN_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [LEN_W-1:0]  size,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_good,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic [3:0]        out_be,
  output logic [WIDX_W-1:0] out_widx,
  output logic              done,
  output logic [LEN_W-1:0]  length,
  output logic              ok
);
  logic              inframe, trunc, good, pend;
  logic [LEN_W-1:0]  stored;
  logic [31:0]       word;
  logic [3:0]        be;
  logic [WIDX_W-1:0] widx;

  logic              take, active, fits, flush;
  logic [LEN_W-1:0]  pos;
  logic [1:0]        lane;
  logic [31:0]       nword;
  logic [3:0]        nbe;

  assign in_ready = en && !out_valid && !done && !pend;
  assign take     = in_valid && in_ready;
  assign active   = inframe || in_sof;
  assign pos      = in_sof ? '0 : stored;
  assign fits     = pos < size;
  assign lane     = pos[1:0];

  always_comb begin
    nword = in_sof ? '0 : word;
    nbe   = in_sof ? 4'b0000 : be;
    for (int b = 0; b < 4; b++) begin
      if (fits && lane == 2'(b)) begin
        nword[8*b +: 8] = in_data;
        nbe[b]          = 1'b1;
      end
    end
    flush = (fits && lane == 2'd3) || (in_eof && nbe != 4'b0000);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      inframe   <= 1'b0;
      trunc     <= 1'b0;
      good      <= 1'b0;
      pend      <= 1'b0;
      done      <= 1'b0;
      stored    <= '0;
      word      <= '0;
      be        <= '0;
      widx      <= '0;
      out_valid <= 1'b0;
    end else begin
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        be        <= '0;
        widx      <= widx + WIDX_W'(1);
        if (pend) begin
          pend <= 1'b0;
          done <= 1'b1;
        end
      end
      if (take && active) begin
        if (in_sof) widx <= '0;
        word      <= nword;
        be        <= nbe;
        stored    <= fits ? pos + LEN_W'(1) : pos;
        trunc     <= (in_sof ? 1'b0 : trunc) | !fits;
        out_valid <= flush;
        inframe   <= !in_eof;
        if (in_eof) begin
          good <= in_good;
          if (flush) pend <= 1'b1;
          else       done <= 1'b1;
        end
      end
    end
  end

  assign out_data = word;
  assign out_be   = be;
  assign out_widx = widx;
  assign length   = stored;
  assign ok       = good && !trunc;
endmodule

// File: rtl/rxd_ring_engine.sv
module rxd_ring_engine #(
  parameter int AW    = 32,
  parameter int LEN_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          kick,
  output logic          stalled,
  output logic          frame_done,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_good,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  output logic [3:0]    mem_req_be,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data
);
  import rxd_pkg::*;
  localparam int WIDX_W = LEN_W - 2;

  rxd_state_e    state;
  logic [AW-1:0] desc_ptr;
  logic [1:0]    fidx;
  logic          rq_valid, rq_write, done_q;
  logic [AW-1:0] rq_addr;
  logic [31:0]   rq_wdata;

  logic              desc_own;
  logic [LEN_W-1:0]  desc_size;
  logic [AW-1:0]     desc_link, desc_buf;
  logic              rsp_take, enter_recv;

  logic              pk_in_ready, pk_out_valid, pk_done, pk_ok;
  logic [31:0]       pk_data;
  logic [3:0]        pk_be;
  logic [WIDX_W-1:0] pk_widx;
  logic [LEN_W-1:0]  pk_len;
  logic [31:0]       wb_word;

  // fetch sequence: status word first, then link, then buffer
  function automatic logic [AW-1:0] fetch_ofs(input logic [1:0] i);
    case (i)
      2'd0:    return AW'(4);
      2'd1:    return AW'(0);
      default: return AW'(8);
    endcase
  endfunction

  assign rsp_take   = (state == ST_RD_WAIT) && mem_rsp_valid;
  assign enter_recv = rsp_take && fidx == 2'd2;

  rxd_desc_latch #(.AW(AW), .LEN_W(LEN_W)) u_desc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rsp_take),
    .sel      (fidx),
    .word     (mem_rsp_data),
    .own      (desc_own),
    .size     (desc_size),
    .link     (desc_link),
    .buf_base (desc_buf)
  );

  rxd_packer #(.LEN_W(LEN_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (enter_recv),
    .en        (state == ST_RECV),
    .size      (desc_size),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_sof    (in_sof),
    .in_eof    (in_eof),
    .in_good   (in_good),
    .in_ready  (pk_in_ready),
    .out_valid (pk_out_valid),
    .out_ready (mem_req_ready && state == ST_RECV),
    .out_data  (pk_data),
    .out_be    (pk_be),
    .out_widx  (pk_widx),
    .done      (pk_done),
    .length    (pk_len),
    .ok        (pk_ok)
  );

  always_comb begin
    wb_word              = '0;
    wb_word[OK_BIT]      = pk_ok;
    wb_word[LEN_W-1:0]   = pk_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      desc_ptr <= '0;
      fidx     <= '0;
      rq_valid <= 1'b0;
      rq_write <= 1'b0;
      rq_addr  <= '0;
      rq_wdata <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (kick) begin
          desc_ptr <= ring_base;
          fidx     <= 2'd0;
          rq_valid <= 1'b1;
          rq_write <= 1'b0;
          rq_addr  <= ring_base + fetch_ofs(2'd0);
          state    <= ST_RD_ISSUE;
        end
        ST_RD_ISSUE: if (mem_req_ready) begin
          rq_valid <= 1'b0;
          state    <= ST_RD_WAIT;
        end
        ST_RD_WAIT: if (mem_rsp_valid) begin
          if (fidx == 2'd0 && !mem_rsp_data[OWN_BIT]) begin
            state <= ST_STALL;
          end else if (fidx == 2'd2) begin
            state <= ST_RECV;
          end else begin
            fidx     <= fidx + 2'd1;
            rq_valid <= 1'b1;
            rq_addr  <= desc_ptr + fetch_ofs(fidx + 2'd1);
            state    <= ST_RD_ISSUE;
          end
        end
        ST_STALL: if (kick) begin
          fidx     <= 2'd0;
          rq_valid <= 1'b1;
          rq_write <= 1'b0;
          rq_addr  <= desc_ptr + fetch_ofs(2'd0);
          state    <= ST_RD_ISSUE;
        end
        ST_RECV: if (pk_done) begin
          rq_valid <= 1'b1;
          rq_write <= 1'b1;
          rq_addr  <= desc_ptr + AW'(4);
          rq_wdata <= wb_word;
          state    <= ST_WB;
        end
        ST_WB: if (mem_req_ready) begin
          done_q   <= 1'b1;
          desc_ptr <= desc_link;
          fidx     <= 2'd0;
          rq_valid <= 1'b1;
          rq_write <= 1'b0;
          rq_addr  <= desc_link + fetch_ofs(2'd0);
          state    <= ST_RD_ISSUE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (state == ST_RECV) begin
      mem_req_valid = pk_out_valid;
      mem_req_write = 1'b1;
      mem_req_addr  = desc_buf + AW'({pk_widx, 2'b00});
      mem_req_wdata = pk_data;
      mem_req_be    = pk_be;
    end else begin
      mem_req_valid = rq_valid;
      mem_req_write = rq_write;
      mem_req_addr  = rq_addr;
      mem_req_wdata = rq_wdata;
      mem_req_be    = 4'hF;
    end
  end

  assign in_ready   = (state == ST_RECV) ? pk_in_ready : (state == ST_STALL);
  assign stalled    = (state == ST_STALL);
  assign frame_done = done_q;

  // desc_own is kept for the checker's view of the latched descriptor
  logic own_seen;
  assign own_seen = desc_own;
endmodule

// File: rtl/rxd_ring_checker.sv
module rxd_ring_checker #(
  parameter int AW    = 32,
  parameter int LEN_W = 12
) (
  input logic                clk,
  input logic                rst_n,
  input rxd_pkg::rxd_state_e state,
  input logic                in_ready,
  input logic                stalled,
  input logic                frame_done,
  input logic                mem_req_valid,
  input logic                mem_req_ready,
  input logic                mem_req_write,
  input logic [AW-1:0]       mem_req_addr,
  input logic [31:0]         mem_req_wdata,
  input logic                pk_out_valid,
  input logic [LEN_W-1:0]    desc_size,
  input logic                own_seen
);
  import rxd_pkg::*;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)); // R9

  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_RD_WAIT |-> !mem_req_valid); // R9

  AST_INPUT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ISSUE || state == ST_RD_WAIT || state == ST_WB) |-> !in_ready); // R10

  AST_STALL_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> in_ready && !mem_req_valid); // R3

  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WB |-> mem_req_valid && mem_req_write && !mem_req_wdata[OWN_BIT]); // R6

  AST_WB_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WB |-> !pk_out_valid); // R6

  AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WB |-> mem_req_wdata[LEN_W-1:0] <= desc_size && own_seen); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R11
endmodule

bind rxd_ring_engine rxd_ring_checker #(.AW(AW), .LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .state         (state),
  .in_ready      (in_ready),
  .stalled       (stalled),
  .frame_done    (frame_done),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .pk_out_valid  (pk_out_valid),
  .desc_size     (desc_size),
  .own_seen      (own_seen)
);

// File: tb/sim_rxd_ring_engine.sv
module sim_rxd_ring_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = '0;
  logic        kick = 1'b0;
  logic        stalled, frame_done;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_good = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  rxd_ring_engine u0 (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .kick(kick),
    .stalled(stalled), .frame_done(frame_done),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_good(in_good),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int checks = 0;
  int errors = 0;

  // memory model: 256 words, ready gaps, read data two edges after accept
  logic [31:0] mem [0:255];
  logic [31:0] cyc = '0;
  logic        rd_pend = 1'b0;
  logic [31:0] rd_addr = '0;
  logic [31:0] rdlog [0:2];
  int          nrd = 0;
  logic [31:0] last_rd = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    mem_rsp_valid <= 1'b0;
    if (rd_pend) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= mem[rd_addr[9:2]];
      rd_pend       <= 1'b0;
    end
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        for (int b = 0; b < 4; b++)
          if (mem_req_be[b]) mem[mem_req_addr[9:2]][8*b +: 8] = mem_req_wdata[8*b +: 8];
      end else begin
        rd_pend <= 1'b1;
        rd_addr <= mem_req_addr;
        if (nrd < 3) rdlog[nrd] = mem_req_addr;
        nrd = nrd + 1;
        last_rd = mem_req_addr;
      end
    end
  end

  // port monitors for R9, R10, R11
  int          viol_hold = 0, viol_block = 0, done_cnt = 0;
  logic        p_stuck = 1'b0;
  logic [31:0] p_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_stuck && (!mem_req_valid || mem_req_addr != p_addr)) viol_hold++;
      if (mem_req_valid && (!mem_req_write || mem_req_addr < 32'h100) && in_ready) viol_block++;
      if (frame_done) done_cnt++;
    end
    p_stuck = rst_n && mem_req_valid && !mem_req_ready;
    p_addr  = mem_req_addr;
  end

  // columns: frame length, posted size, expected length, {good, expected ok}
  localparam logic [31:0] VEC [0:5] = '{
    {8'd20, 8'd64, 8'd20, 8'h11},
    {8'd7,  8'd64, 8'd7,  8'h11},
    {8'd33, 8'd64, 8'd33, 8'h00},
    {8'd40, 8'd24, 8'd24, 8'h10},
    {8'd30, 8'd30, 8'd30, 8'h11},
    {8'd50, 8'd13, 8'd13, 8'h10}
  };

  function automatic logic [7:0] pat(input int tag, input int k);
    return 8'(tag * 37 + k * 5 + 1);
  endfunction

  task automatic chk(input bit cond, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic arm(input int d, input int size);
    mem[d*8 + 1] = 32'h8000_0000 | 32'(size);
  endtask

  task automatic fill(input int base);
    for (int w = 0; w < 16; w++) mem[base/4 + w] = 32'hEEEE_EEEE;
  endtask

  task automatic send_frame(input int tag, input int n, input bit good, input bit framed);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b1;
      in_data  = pat(tag, k);
      in_sof   = framed && (k == 0);
      in_eof   = framed && (k == n - 1);
      in_good  = good;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
  endtask

  task automatic wait_done;
    while (!frame_done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_buf(input int base, input int tag, input int explen, input string req);
    int bad = 0;
    logic [7:0] a = '0, e = '0;
    for (int k = 0; k < 64; k++) begin
      logic [7:0] got, want;
      got  = mem[(base + k) / 4][8*((base + k) % 4) +: 8];
      want = (k < explen) ? pat(tag, k) : 8'hEE;
      if (got != want && bad == 0) begin a = got; e = want; end
      if (got != want) bad++;
    end
    chk(bad == 0, req, "buffer bytes", 32'(a), 32'(e));
  endtask

  initial begin
    logic [31:0] saved;
    for (int w = 0; w < 256; w++) mem[w] = '0;
    mem[0] = 32'h20;  mem[2]  = 32'h100;
    mem[8] = 32'h00;  mem[10] = 32'h200;
    arm(0, 32'(VEC[0][23:16]));
    arm(1, 32'(VEC[1][23:16]));
    fill(32'h100); fill(32'h200);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!mem_req_valid && !in_ready && !stalled && !frame_done, "R1", "idle outputs",
        {28'b0, mem_req_valid, in_ready, stalled, frame_done}, 32'h0);
    kick = 1'b1; @(negedge clk); kick = 1'b0;
    while (nrd < 3) @(negedge clk);
    chk(rdlog[0] == 32'h4 && rdlog[1] == 32'h0 && rdlog[2] == 32'h8, "R2", "fetch order",
        {rdlog[0][7:0], rdlog[1][7:0], rdlog[2][7:0], 8'h0}, 32'h0400_0800);

    for (int i = 0; i < 6; i++) begin
      int d, base, flen, elen;
      bit good, eok;
      logic [31:0] st;
      flen = int'(VEC[i][31:24]);
      elen = int'(VEC[i][15:8]);
      good = VEC[i][4];
      eok  = VEC[i][0];
      d    = i % 2;
      base = d ? 32'h200 : 32'h100;
      send_frame(i, flen, good, 1'b1);
      wait_done;
      st = mem[d*8 + 1];
      chk(st == ((32'(eok) << 27) | 32'(elen)), (elen < flen) ? "R7" : "R6",
          "status write-back", st, (32'(eok) << 27) | 32'(elen));
      check_buf(base, i, elen, (elen < flen) ? "R7" : "R4");
      fill(base);
      if (i + 2 < 6) arm(d, 32'(VEC[i+2][23:16]));
    end

    // ring wrapped to descriptor 0, whose ownership is still with the host
    repeat (30) @(negedge clk);
    chk(stalled && in_ready, "R3", "stall with input drained", {30'b0, stalled, in_ready}, 32'h3);
    chk(last_rd == 32'h4, "R8", "ring wrap read address", last_rd, 32'h4);
    saved = mem[1];
    send_frame(9, 8, 1'b1, 1'b1);
    repeat (10) @(negedge clk);
    check_buf(32'h100, 9, 0, "R3");
    chk(mem[1] == saved, "R3", "status untouched while stalled", mem[1], saved);

    arm(0, 64);
    kick = 1'b1; @(negedge clk); kick = 1'b0;
    send_frame(11, 3, 1'b1, 1'b0);       // stray bytes outside a frame
    send_frame(10, 9, 1'b1, 1'b1);
    wait_done;
    chk(mem[1] == 32'h0800_0009, "R5", "status after stray bytes", mem[1], 32'h0800_0009);
    check_buf(32'h100, 10, 9, "R5");

    repeat (20) @(negedge clk);
    chk(viol_hold == 0, "R9", "request changed under back-pressure", 32'(viol_hold), 0);
    chk(viol_block == 0, "R10", "input open during descriptor traffic", 32'(viol_block), 0);
    chk(done_cnt == 7, "R11", "frame_done pulse count", 32'(done_cnt), 7);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule